// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of a small machine built around one 8-bit accumulator. Each request gives it the accumulator, an 8-bit operand (already fetched from memory or taken from an immediate), a 4-bit operation code and the current condition-code byte. It works out the new accumulator and the new condition-code byte. Each operation writes only its own fixed set of the carry, zero, overflow and negative flags. All other flags pass through unchanged.

The operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR, complement, and arithmetic shifts left and right by the operand used as a count. The result goes into a registered output stage. A valid strobe marks the cycle after each accepted request. When no request arrives, the registered results hold their values. Decoding, operand fetch and memory access belong to the surrounding datapath.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 is ADD and code 1 is ADC. The result is A + operand (+ C for ADC). C takes the carry out of bit 7. V is set on signed overflow. Z is set when the result is zero. N takes bit 7 of the result.
- R2: Operation code 2 is SUB and code 3 is SBB. The result is A - operand (- C for SBB). C is set when a borrow occurs, that is when operand (+ C for SBB) exceeds A as an unsigned value. V is set on signed overflow. Z and N follow the result.
- R3: Operation code 4 is CMP. It sets C, Z, V and N exactly as SUB would, and the registered accumulator equals the incoming A.
- R4: Operation codes 5, 6 and 7 are AND, OR and XOR. Z and N follow the result, V is cleared, and C keeps its incoming value.
- R5: Operation code 8 is NOT. The result is the bitwise complement of A. C is set to 1, V is cleared, and Z and N follow the result.
- R6: Operation code 9 is SHL by the operand as a count n ≥ 1. The result is A shifted left n places with zeros filled in. C takes the last bit shifted out, which is 0 when n > 8. V is set when bit 7 of the result differs from bit 7 of A. Z and N follow the result.
- R7: Operation code 10 is SHR by n ≥ 1. The result is A shifted right n places with copies of bit 7 filled in. C takes the last bit shifted out, which is bit 7 of A when n > 8. Z and N follow the result. V keeps its incoming value.
- R8: SHL or SHR with a count of 0 leaves A and C unchanged. Z and N follow A. V is cleared by SHL and kept by SHR.
- R9: The condition-code byte places C at bit 0, Z at bit 1, V at bit 2, N at bit 3, the interrupt mask at bit 4 and the single-step flag at bit 5. Bits 4 and 5 always pass through unchanged. Bits 6 and 7 of the output are always 0.
- R10: Operation codes 11 to 15 are reserved. They leave A and bits 0 to 3 of the condition code unchanged.
- R11: A request accepted with `in_valid` high at a clock edge appears on `acc_out` and `cc_out`, with `out_valid` high, right after that edge. When `in_valid` is low at an edge, `out_valid` goes low and both results hold their values.
- R12: While reset is asserted, `out_valid`, `acc_out` and `cc_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator |
| operand | input | 8 | Operand byte or shift count |
| cc_in | input | 8 | Current condition-code byte |
| out_valid | output | 1 | Registered result valid |
| acc_out | output | 8 | New accumulator |
| cc_out | output | 8 | New condition-code byte |

## Verification
A fault in the carry or overflow logic shows on `cc_out` in the cycle right after the request. The same holds for a wrong flag write-enable set. No later state depends on it, so every fault is visible in one cycle and tied to a single vector. The bench sweeps all sixteen operation codes over a dense grid of accumulator and operand values. The grid covers every shift count from 0 to 19 and the signed limits 127 and 128. The condition-code input rotates through patterns that set the control bits and the unused top bits. A fault in the hold path shows when the strobe drops and the registered results change even though no request arrived.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int CC_W   = 8;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 2;
  localparam int FLAG_N = 3;
  localparam int FLAG_I = 4;
  localparam int FLAG_S = 5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              carry;
    logic              ovf;
  } addsub_t;

  // Adder shared by add and subtract; for subtract, carry reports a borrow.
  function automatic addsub_t addsub(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic              cin,
                                     input logic              sub);
    addsub_t           r;
    logic [DATA_W-1:0] b_eff;
    logic              ci;
    logic [DATA_W:0]   sum;
    b_eff   = sub ? ~b : b;
    ci      = sub ? ~cin : cin;
    sum     = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, ci};
    r.res   = sum[DATA_W-1:0];
    r.carry = sub ? ~sum[DATA_W] : sum[DATA_W];
    r.ovf   = (a[DATA_W-1] == b_eff[DATA_W-1]) && (r.res[DATA_W-1] != a[DATA_W-1]);
    return r;
  endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  addsub_t r;
  assign r     = addsub(a, b, cin, sub);
  assign res   = r.res;
  assign carry = r.carry;
  assign ovf   = r.ovf;
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] res
);
  // sel: 0 AND, 1 OR, 2 XOR, 3 complement of a
  always_comb begin
    case (sel)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      2'd2:    res = a ^ b;
      default: res = ~a;
    endcase
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] cnt,
  input  logic         right,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         sign_flip,
  output logic         cnt_zero
);
  logic [2*W-1:0] wide_l;
  logic [2*W-1:0] wide_r;
  logic           unused_wide;

  // Bit just below the kept field is the last bit shifted out.
  assign wide_l      = {{W{1'b0}}, a} << cnt;
  assign wide_r      = $unsigned($signed({a, {W{1'b0}}}) >>> cnt);
  assign cnt_zero    = (cnt == '0);
  assign unused_wide = ^{wide_l[2*W-1:W+1], wide_r[W-2:0]};

  always_comb begin
    if (cnt_zero) begin
      res  = a;
      cout = cin;
    end else if (right) begin
      res  = wide_r[2*W-1:W];
      cout = wide_r[W-1];
    end else begin
      res  = wide_l[W-1:0];
      cout = wide_l[W];
    end
  end

  assign sign_flip = res[W-1] ^ a[W-1];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] operand,
  input  logic [CC_W-1:0]   cc_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] acc_out,
  output logic [CC_W-1:0]   cc_out
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // Named events for the checks below
  logic op_is_sub, op_uses_cin, op_is_logic, op_is_shift, op_is_rsvd;
  assign op_is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
  assign op_uses_cin = (op_e == OP_ADC) || (op_e == OP_SBB);
  assign op_is_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
  assign op_is_shift = (op_e == OP_SHL) || (op_e == OP_SHR);
  assign op_is_rsvd  = (op > 4'd10);

  logic [DATA_W-1:0] as_res, lg_res, sh_res;
  logic              as_carry, as_ovf, sh_cout, sh_flip, cnt_zero;
  logic [1:0]        lg_sel;

  acc_alu_addsub #(.W(DATA_W)) u_addsub (
    .a(acc_in), .b(operand), .cin(op_uses_cin & cc_in[FLAG_C]), .sub(op_is_sub),
    .res(as_res), .carry(as_carry), .ovf(as_ovf)
  );

  assign lg_sel = (op_e == OP_NOT) ? 2'd3 : (op[1:0] - 2'd1);

  acc_alu_logic #(.W(DATA_W)) u_logic (
    .a(acc_in), .b(operand), .sel(lg_sel), .res(lg_res)
  );

  acc_alu_shift #(.W(DATA_W)) u_shift (
    .a(acc_in), .cnt(operand), .right(op_e == OP_SHR), .cin(cc_in[FLAG_C]),
    .res(sh_res), .cout(sh_cout), .sign_flip(sh_flip), .cnt_zero(cnt_zero)
  );

  logic [DATA_W-1:0] acc_nxt, zn_src;
  logic              f_c, f_z, f_v, f_n, upd_zn;
  logic [CC_W-1:0]   cc_nxt;
  logic              unused_cc_hi;
  assign unused_cc_hi = ^cc_in[CC_W-1:FLAG_S+1];

  always_comb begin
    acc_nxt = acc_in;
    zn_src  = acc_in;
    upd_zn  = 1'b0;
    f_c     = cc_in[FLAG_C];
    f_z     = cc_in[FLAG_Z];
    f_v     = cc_in[FLAG_V];
    f_n     = cc_in[FLAG_N];
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_nxt = as_res; zn_src = as_res; upd_zn = 1'b1;
        f_c = as_carry; f_v = as_ovf;
      end
      OP_CMP: begin
        zn_src = as_res; upd_zn = 1'b1;
        f_c = as_carry; f_v = as_ovf;
      end
      OP_AND, OP_OR, OP_XOR: begin
        acc_nxt = lg_res; zn_src = lg_res; upd_zn = 1'b1;
        f_v = 1'b0;
      end
      OP_NOT: begin
        acc_nxt = lg_res; zn_src = lg_res; upd_zn = 1'b1;
        f_v = 1'b0; f_c = 1'b1;
      end
      OP_SHL: begin
        acc_nxt = sh_res; zn_src = sh_res; upd_zn = 1'b1;
        f_c = sh_cout; f_v = sh_flip;
      end
      OP_SHR: begin
        acc_nxt = sh_res; zn_src = sh_res; upd_zn = 1'b1;
        f_c = sh_cout;
      end
      default: ;
    endcase
    if (upd_zn) begin
      f_z = (zn_src == '0);
      f_n = zn_src[DATA_W-1];
    end
    cc_nxt         = '0;
    cc_nxt[FLAG_C] = f_c;
    cc_nxt[FLAG_Z] = f_z;
    cc_nxt[FLAG_V] = f_v;
    cc_nxt[FLAG_N] = f_n;
    cc_nxt[FLAG_I] = cc_in[FLAG_I];
    cc_nxt[FLAG_S] = cc_in[FLAG_S];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      cc_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out <= acc_nxt;
        cc_out  <= cc_nxt;
      end
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(acc_out) && $stable(cc_out)));
  // R9
  ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cc_out[FLAG_S:FLAG_I] == $past(cc_in[FLAG_S:FLAG_I]))
                 && (cc_out[CC_W-1:FLAG_S+1] == '0));
  // R3
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_CMP) |=> (acc_out == $past(acc_in)));
  // R4
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_logic) |=> (cc_out[FLAG_C] == $past(cc_in[FLAG_C])) && !cc_out[FLAG_V]);
  // R8
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_shift && cnt_zero) |=>
      (acc_out == $past(acc_in)) && (cc_out[FLAG_C] == $past(cc_in[FLAG_C])));
  // R7
  shr_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_SHR) |=> (cc_out[FLAG_V] == $past(cc_in[FLAG_V])));
  // R10
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_rsvd) |=>
      (acc_out == $past(acc_in)) && (cc_out[FLAG_N:FLAG_C] == $past(cc_in[FLAG_N:FLAG_C])));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] operand = '0;
  logic [7:0] cc_in = '0;
  logic       out_valid;
  logic [7:0] acc_out;
  logic [7:0] cc_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_in(acc_in),
    .operand(operand), .cc_in(cc_in), .out_valid(out_valid), .acc_out(acc_out),
    .cc_out(cc_out)
  );

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Reference: returns {acc[15:8], cc[7:0]} from the requirement text.
  function automatic int model(input int o, input int a, input int b, input int cc);
    int r, c, z, v, n, d, t;
    bit zn;
    r = a; c = cc & 1; z = (cc >> 1) & 1; v = (cc >> 2) & 1; n = (cc >> 3) & 1;
    zn = 1'b1;
    case (o)
      0, 1: begin
        t = a + b + ((o == 1) ? c : 0);
        c = (t > 255) ? 1 : 0;
        d = sx(a) + sx(b) + ((o == 1) ? (cc & 1) : 0);
        v = (d > 127 || d < -128) ? 1 : 0;
        r = t & 255;
      end
      2, 3, 4: begin
        t = a - b - ((o == 3) ? c : 0);
        c = (t < 0) ? 1 : 0;
        d = sx(a) - sx(b) - ((o == 3) ? (cc & 1) : 0);
        v = (d > 127 || d < -128) ? 1 : 0;
        r = t & 255;
      end
      5: begin r = a & b; v = 0; end
      6: begin r = a | b; v = 0; end
      7: begin r = a ^ b; v = 0; end
      8: begin r = (~a) & 255; v = 0; c = 1; end
      9: begin
        for (int i = 0; i < b; i++) begin
          c = (r >> 7) & 1;
          r = (r << 1) & 255;
        end
        v = ((r >> 7) & 1) ^ ((a >> 7) & 1);
      end
      10: begin
        for (int i = 0; i < b; i++) begin
          c = r & 1;
          r = (r >> 1) | (r & 128);
        end
      end
      default: zn = 1'b0;
    endcase
    if (zn) begin
      z = (r == 0) ? 1 : 0;
      n = (r >> 7) & 1;
    end
    if (o == 4) r = a;
    return (r << 8) | (cc & 8'h30) | (n << 3) | (v << 2) | (z << 1) | c;
  endfunction

  function automatic string req_of(input int o, input int b);
    if ((o == 9 || o == 10) && b == 0) return "R8";
    case (o)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4:       return "R3";
      5, 6, 7: return "R4";
      8:       return "R5";
      9:       return "R6";
      10:      return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt_vec;
    int exp;
    int a, b, cc;
    int last_acc, last_cc;
    cnt_vec = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "out_valid in reset", int'(out_valid), 0);
    check("R12", "acc_out in reset", int'(acc_out), 0);
    check("R12", "cc_out in reset", int'(cc_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "out_valid after reset", int'(out_valid), 0);

    for (int o = 0; o < 16; o++) begin
      for (int ai = 0; ai < 88; ai++) begin
        for (int bi = 0; bi < 37; bi++) begin
          a  = (ai < 86) ? ai * 3 : ((ai == 86) ? 127 : 128);
          b  = (bi < 20) ? bi : ((bi == 36) ? 255 : bi * 7);
          cc = (cnt_vec * 37 + 11) & 255;
          cnt_vec++;
          @(negedge clk);
          in_valid = 1'b1;
          op       = o[3:0];
          acc_in   = a[7:0];
          operand  = b[7:0];
          cc_in    = cc[7:0];
          @(posedge clk);
          #1;
          exp = model(o, a, b, cc);
          check("R11", "out_valid", int'(out_valid), 1);
          check(req_of(o, b), $sformatf("acc op=%0d a=%0d b=%0d cc=%0h", o, a, b, cc),
                int'(acc_out), (exp >> 8) & 255);
          check(req_of(o, b), $sformatf("flags op=%0d a=%0d b=%0d cc=%0h", o, a, b, cc),
                int'(cc_out[3:0]), exp & 15);
          check("R9", $sformatf("ctrl bits op=%0d cc=%0h", o, cc),
                int'(cc_out[7:4]), (cc >> 4) & 3);
        end
      end
    end

    // R11 hold while idle: inputs change but no request
    last_acc = int'(acc_out);
    last_cc  = int'(cc_out);
    @(negedge clk);
    in_valid = 1'b0;
    op       = 4'd8;
    acc_in   = 8'h5A;
    cc_in    = 8'h0F;
    @(posedge clk);
    #1;
    check("R11", "out_valid idle", int'(out_valid), 0);
    check("R11", "acc_out hold", int'(acc_out), last_acc);
    check("R11", "cc_out hold", int'(cc_out), last_cc);
    @(posedge clk);
    #1;
    check("R11", "acc_out hold 2", int'(acc_out), last_acc);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule